// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes two-channel PCM audio from a serial link made of a bit clock, a word clock and one or two data lines, and turns it into a parallel pair of 24-bit two's-complement samples with a one-cycle valid strobe. Every register runs on the bit clock, which is the block's `clk`. The data and word-clock lines are sampled on its rising edge. Moving the samples into another clock domain is done outside the block.

Two static select inputs choose one of three framings. In the first, left and right samples take turns on one data line and each sample sits at the end of its word-clock half. Its length comes from a 2-bit code on two auxiliary pins. In the second, the samples also take turns on one line, but each sample starts at the word-clock transition and is always 24 bits long. In the third, both channels arrive at the same time on the two auxiliary pins, which then carry audio rather than a length code, and each frame starts at the rising edge of the word clock.

Samples shorter than 24 bits are placed at the top of the output word and filled with zeros below. Both output channels change together, in the cycle the strobe is high.

Top module: `sar_rx`

## Requirements
- R1: A synchronous active-high reset sets `left_o`, `right_o` and `valid_o` to zero.
- R2: With `sel_fmt_a` low, the format is right-aligned alternating on `sd_main`, and `sel_fmt_b` has no effect.
- R3: With `sel_fmt_a` high and `sel_fmt_b` low, the format is left-aligned alternating on `sd_main`. The first 24 bits after each word-clock transition form the sample. `sd_l_len1` and `sd_r_len0` have no effect in this format.
- R4: With both selects high, left data arrives on `sd_l_len1` and right data on `sd_r_len0` at the same time. A frame starts at the bit where the word clock is first sampled high, its first 24 bits form the sample, and `sd_main` has no effect.
- R5: In the right-aligned format, the code {`sd_l_len1`,`sd_r_len0`} sets the length N. Code 00 gives 24 bits, 01 gives 22, 10 gives 18 and 11 gives 16. The sample is the last N bits before a word-clock transition.
- R6: A sample shorter than 24 bits occupies output bits 23 down to 24-N, and the bits below are zero.
- R7: Data is taken MSB first on rising `clk` edges. A word-clock high level marks the left channel, and a left/right pair completes at a low-to-high word-clock transition.
- R8: `valid_o` is high for exactly one cycle per completed pair. It is high in the cycle right after the rising edge that first samples the word clock high, and both outputs take their new values in that same cycle.
- R9: After reset, no pair is reported until a complete half (alternating formats) or a complete frame (dual-line format) has been seen. A partial half or frame that is already in progress at reset is discarded.
- R10: Between strobes, `left_o` and `right_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all logic on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_fmt_a | input | 1 | Format select, first level |
| sel_fmt_b | input | 1 | Format select, second level (used only when `sel_fmt_a` is high) |
| wclk | input | 1 | Word clock; high = left channel |
| sd_main | input | 1 | Serial data for the alternating formats |
| sd_l_len1 | input | 1 | Length code bit 1 (right-aligned) or left data (dual-line) |
| sd_r_len0 | input | 1 | Length code bit 0 (right-aligned) or right data (dual-line) |
| left_o | output | 24 | Left sample, MSB-aligned two's complement |
| right_o | output | 24 | Right sample, MSB-aligned two's complement |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
The bench puts random filler bits in front of right-aligned samples and behind left-aligned ones, and it varies the half lengths down to exactly N bits. A receiver that took the wrong window or the wrong length would return shifted or polluted samples.

Every length code is run with 0x800000 and 0xFFFFFF as samples. A padding or alignment fault therefore shows up in the sign bit or in the zero-filled low bits.

The bench toggles inputs that a format must ignore on every bit: the second select in right-aligned mode, the auxiliary pins in left-aligned mode, and the main line in dual-line mode. A decoder that leaked any of them would corrupt the data.

The strobe is predicted for each cycle and must appear exactly one cycle after the first high word-clock bit. A pair must not be reported for the partial period after reset, and the outputs must not drift between strobes.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SAMPLE_W = 24;
    localparam int POS_W    = $clog2(SAMPLE_W + 1);

    typedef enum logic [1:0] {
        FMT_RJ   = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_DUAL = 2'd2
    } fmt_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] l;
        logic [SAMPLE_W-1:0] r;
    } pair_t;

    // decode the two static select levels into a framing
    function automatic fmt_e decode_fmt(input logic a, input logic b);
        if (!a)     return FMT_RJ;
        else if (!b) return FMT_LJ;
        else        return FMT_DUAL;
    endfunction

    // right-aligned sample length for a 2-bit code
    function automatic logic [POS_W-1:0] len_of_code(input logic [1:0] code);
        case (code)
            2'b00:   return POS_W'(24);
            2'b01:   return POS_W'(22);
            2'b10:   return POS_W'(18);
            default: return POS_W'(16);
        endcase
    endfunction

    // move the low n bits of a shift register to the top of the word
    function automatic logic [SAMPLE_W-1:0] msb_align(input logic [SAMPLE_W-1:0] tail,
                                                      input logic [POS_W-1:0]    n);
        logic [POS_W-1:0] sh;
        sh = POS_W'(SAMPLE_W) - n;
        return tail << sh;
    endfunction

    // ones in the top n bits
    function automatic logic [SAMPLE_W-1:0] top_mask(input logic [POS_W-1:0] n);
        return ~({SAMPLE_W{1'b1}} >> n);
    endfunction

endpackage

// File: rtl/sar_wclk_track.sv
module sar_wclk_track
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wclk_i,
    input  fmt_e             fmt_i,
    output logic             restart_o,
    output logic             old_lvl_o,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] POS_MAX = POS_W'(SAMPLE_W);

    logic             prev_q;
    logic             primed_q;
    logic [POS_W-1:0] cnt_q;
    logic             edge_seen;

    assign edge_seen = primed_q && (wclk_i != prev_q);
    // dual-line frames restart only on the rising word-clock edge
    assign restart_o = edge_seen && ((fmt_i != FMT_DUAL) || wclk_i);
    assign old_lvl_o = prev_q;
    assign pos_o     = restart_o ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
            cnt_q    <= POS_MAX;
        end else begin
            prev_q   <= wclk_i;
            primed_q <= 1'b1;
            if (restart_o)
                cnt_q <= POS_W'(1);
            else if (cnt_q < POS_MAX)
                cnt_q <= cnt_q + POS_W'(1);
        end
    end

    // R3: bit position never runs past the sample width
    always_comb begin
        assert_pos_bound_R3: assert (pos_o <= POS_MAX)
            else $error("bit position out of range");
    end

endmodule

// File: rtl/sar_lane.sv
module sar_lane
    import sar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                d_i,
    input  logic                restart_i,
    input  logic [POS_W-1:0]    pos_i,
    input  fmt_e                fmt_i,
    input  logic [1:0]          len_code_i,
    output logic [SAMPLE_W-1:0] word_o
);
    localparam logic [POS_W-1:0] POS_MAX = POS_W'(SAMPLE_W);

    logic [SAMPLE_W-1:0] tail_q;   // most recent bits, for right-aligned data
    logic [SAMPLE_W-1:0] head_q;   // first bits after a restart
    logic [POS_W-1:0]    n_bits;

    assign n_bits = (fmt_i == FMT_RJ) ? len_of_code(len_code_i) : POS_MAX;

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= '0;
            head_q <= '0;
        end else begin
            tail_q <= {tail_q[SAMPLE_W-2:0], d_i};
            if (restart_i)
                head_q <= {{(SAMPLE_W-1){1'b0}}, d_i};
            else if (pos_i < POS_MAX)
                head_q <= {head_q[SAMPLE_W-2:0], d_i};
        end
    end

    always_comb begin
        if (fmt_i == FMT_RJ)
            word_o = msb_align(tail_q, n_bits);
        else
            word_o = head_q;
    end

    // R5: only the four defined lengths reach the aligner
    always_comb begin
        assert_len_legal_R5: assert (n_bits == 5'd24 || n_bits == 5'd22 ||
                                     n_bits == 5'd18 || n_bits == 5'd16)
            else $error("illegal sample length");
    end

    // R6: bits below the sample are zero
    always_comb begin
        assert_pad_zero_R6: assert ((word_o & ~top_mask(n_bits)) == '0)
            else $error("padding bits not zero");
    end

endmodule

// File: rtl/sar_pair.sv
module sar_pair
    import sar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  fmt_e                fmt_i,
    input  logic                wclk_i,
    input  logic                restart_i,
    input  logic                old_lvl_i,
    input  logic [SAMPLE_W-1:0] word0_i,
    input  logic [SAMPLE_W-1:0] word1_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    logic                seen_q;
    logic                have_l_q;
    logic [SAMPLE_W-1:0] l_hold_q;
    pair_t               out_q;
    logic                emit;
    pair_t               nxt;
    logic [1:0]          live_q;

    always_comb begin
        emit = 1'b0;
        nxt  = out_q;
        if (restart_i) begin
            if (fmt_i == FMT_DUAL) begin
                emit  = seen_q;
                nxt.l = word0_i;
                nxt.r = word1_i;
            end else if (!old_lvl_i) begin
                emit  = have_l_q;
                nxt.l = l_hold_q;
                nxt.r = word0_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q   <= 1'b0;
            have_l_q <= 1'b0;
            l_hold_q <= '0;
            out_q    <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= emit;
            if (emit)
                out_q <= nxt;
            if (restart_i) begin
                seen_q <= 1'b1;
                if (fmt_i != FMT_DUAL) begin
                    if (old_lvl_i && seen_q) begin
                        l_hold_q <= word0_i;
                        have_l_q <= 1'b1;
                    end else if (!old_lvl_i) begin
                        have_l_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign left_o  = out_q.l;
    assign right_o = out_q.r;

    // cycles since reset, for the checks that look back
    always_ff @(posedge clk) begin
        if (rst)              live_q <= 2'd0;
        else if (live_q != 2'd3) live_q <= live_q + 2'd1;
    end

    // R8: the strobe never lasts two cycles
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R10: outputs hold between strobes
    assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (rst)
        (live_q != 2'd0 && !valid_o) |-> ($stable(left_o) && $stable(right_o)));

    // R7: a pair completes only on a low-to-high word-clock change
    assert_valid_after_rise_R7: assert property (@(posedge clk) disable iff (rst)
        (live_q == 2'd3 && valid_o) |-> ($past(wclk_i) && !$past(wclk_i, 2)));

    // R9: nothing is reported in the first cycles after reset
    assert_no_early_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (live_q != 2'd3) |-> !valid_o);

endmodule

// File: rtl/sar_rx.sv
module sar_rx
    import sar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_fmt_a,
    input  logic                sel_fmt_b,
    input  logic                wclk,
    input  logic                sd_main,
    input  logic                sd_l_len1,
    input  logic                sd_r_len0,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    localparam int LANES = 2;

    fmt_e                fmt;
    logic                restart;
    logic                old_lvl;
    logic [POS_W-1:0]    pos;
    logic [1:0]          len_code;
    logic [LANES-1:0]    lane_d;
    logic [SAMPLE_W-1:0] lane_word [LANES];

    assign fmt      = decode_fmt(sel_fmt_a, sel_fmt_b);
    assign len_code = {sd_l_len1, sd_r_len0};

    // lane 0 takes the single line, or the left line in dual-line mode
    assign lane_d[0] = (fmt == FMT_DUAL) ? sd_l_len1 : sd_main;
    assign lane_d[1] = sd_r_len0;

    sar_wclk_track u_track (
        .clk       (clk),
        .rst       (rst),
        .wclk_i    (wclk),
        .fmt_i     (fmt),
        .restart_o (restart),
        .old_lvl_o (old_lvl),
        .pos_o     (pos)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sar_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .d_i        (lane_d[g]),
            .restart_i  (restart),
            .pos_i      (pos),
            .fmt_i      (fmt),
            .len_code_i (len_code),
            .word_o     (lane_word[g])
        );
    end

    sar_pair u_pair (
        .clk       (clk),
        .rst       (rst),
        .fmt_i     (fmt),
        .wclk_i    (wclk),
        .restart_i (restart),
        .old_lvl_i (old_lvl),
        .word0_i   (lane_word[0]),
        .word1_i   (lane_word[1]),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o)
    );

endmodule

// File: tb/sar_rx_bench.sv
`timescale 1ns/1ps
module sar_rx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_fmt_a = 1'b0, sel_fmt_b = 1'b0;
    logic        wclk = 1'b0, sd_main = 1'b0, sd_l_len1 = 1'b0, sd_r_len0 = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int unsigned n_checks = 0, n_fail = 0;
    bit          exp_fire = 1'b0;
    bit          checking = 1'b0;
    bit          done = 1'b0;
    logic [23:0] last_l = '0, last_r = '0;
    logic [23:0] q_l[$];
    logic [23:0] q_r[$];
    int unsigned cyc = 0;

    always #2.5 clk = ~clk;

    sar_rx u_sar_rx (
        .clk(clk), .rst(rst), .sel_fmt_a(sel_fmt_a), .sel_fmt_b(sel_fmt_b),
        .wclk(wclk), .sd_main(sd_main), .sd_l_len1(sd_l_len1), .sd_r_len0(sd_r_len0),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    function automatic int wl_of(input logic [1:0] c);
        case (c)
            2'b00: return 24;
            2'b01: return 22;
            2'b10: return 18;
            default: return 16;
        endcase
    endfunction

    function automatic logic [23:0] exp_rj(input logic [23:0] s, input int n);
        return s & ~(24'hFFFFFF >> n);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [23:0] got, input logic [23:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // per-cycle monitor, sampled 1 ns after the rising edge
    always @(posedge clk) begin
        bit f;
        f = exp_fire;
        if (checking && !rst) begin
            #1;
            if (f) begin
                chk(valid_o == 1'b1, "R8", "strobe missing", {23'b0, valid_o}, 24'h1);
                if (q_l.size() > 0) begin
                    logic [23:0] el, er;
                    el = q_l.pop_front();
                    er = q_r.pop_front();
                    chk(left_o == el, "R7", "left sample", left_o, el);
                    chk(right_o == er, "R7", "right sample", right_o, er);
                    last_l = el;
                    last_r = er;
                end
            end else begin
                chk(valid_o == 1'b0, "R9", "unexpected strobe", {23'b0, valid_o}, 24'h0);
                chk(left_o == last_l && right_o == last_r, "R10", "outputs drifted",
                    left_o ^ last_l, 24'h0);
            end
        end
    end

    task automatic drive_bit(input logic w, input logic m, input logic a,
                             input logic b, input bit fire);
        @(negedge clk);
        wclk = w; sd_main = m; sd_l_len1 = a; sd_r_len0 = b; exp_fire = fire;
    endtask

    task automatic do_reset;
        @(negedge clk);
        checking = 1'b0;
        exp_fire = 1'b0;
        rst = 1'b1;
        wclk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        last_l = '0;
        last_r = '0;
        q_l.delete();
        q_r.delete();
        @(posedge clk);
        #1;
        // R1: reset clears everything
        chk(left_o == 0 && right_o == 0 && valid_o == 0, "R1", "reset state",
            left_o | right_o | {23'b0, valid_o}, 24'h0);
        checking = 1'b1;
    endtask

    task automatic end_segment;
        logic [23:0] pending;
        drive_bit(1'b1, 1'b0, sd_l_len1, sd_r_len0, 1'b1);
        repeat (4) drive_bit(1'b1, 1'b0, sd_l_len1, sd_r_len0, 1'b0);
        @(negedge clk);
        pending = 24'(q_l.size());
        chk(pending == 0, "R8", "pairs not reported", pending, 24'h0);
    endtask

    // alternating formats; lj=0 right-aligned with length code
    task automatic send_alt(input bit lj, input logic [1:0] code, input int nfr);
        int n;
        n = lj ? 24 : wl_of(code);
        sel_fmt_a = lj;
        sel_fmt_b = 1'b0;
        do_reset();
        repeat (8) drive_bit(1'b0, 1'($urandom), code[1], code[0], 1'b0);
        for (int f = 0; f < nfr; f++) begin
            logic [23:0] s [2];
            logic [23:0] e [2];
            for (int ch = 0; ch < 2; ch++) begin
                s[ch] = 24'($urandom);
                if (f == 0) s[ch] = (ch == 0) ? 24'h800000 : 24'hFFFFFF;
                if (f == 1) s[ch] = (ch == 0) ? 24'hFFFFFF : 24'h800000;
                e[ch] = lj ? s[ch] : exp_rj(s[ch], n);
            end
            q_l.push_back(e[0]);
            q_r.push_back(e[1]);
            for (int ch = 0; ch < 2; ch++) begin
                int h, off;
                h   = n + int'($urandom % 9);
                off = lj ? 0 : h - n;
                for (int i = 0; i < h; i++) begin
                    logic d, a, b;
                    int j;
                    j = i - off;
                    d = (j >= 0 && j < n) ? e[ch][23 - j] : 1'($urandom);
                    // R2: second select toggles freely in right-aligned mode
                    if (!lj) sel_fmt_b = 1'($urandom);
                    // R3: code lines toggle freely in left-aligned mode
                    a = lj ? 1'($urandom) : code[1];
                    b = lj ? 1'($urandom) : code[0];
                    drive_bit(ch == 0, d, a, b, (ch == 0 && i == 0 && f > 0));
                end
            end
        end
        end_segment();
    endtask

    // dual-line format: R4
    task automatic send_dual(input int nfr);
        sel_fmt_a = 1'b1;
        sel_fmt_b = 1'b1;
        do_reset();
        repeat (6) drive_bit(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        for (int f = 0; f < nfr; f++) begin
            logic [23:0] l, r;
            int len, hi;
            l = (f == 0) ? 24'h800000 : 24'($urandom);
            r = (f == 0) ? 24'h7FFFFF : 24'($urandom);
            q_l.push_back(l);
            q_r.push_back(r);
            len = 24 + int'($urandom % 17);
            hi  = len / 2;
            for (int i = 0; i < len; i++) begin
                logic a, b;
                a = (i < 24) ? l[23 - i] : 1'($urandom);
                b = (i < 24) ? r[23 - i] : 1'($urandom);
                drive_bit(i < hi, 1'($urandom), a, b, (i == 0 && f > 0));
            end
        end
        end_segment();
    endtask

    initial begin
        do_reset();
        for (int c = 0; c < 4; c++) send_alt(1'b0, 2'(c), 12);   // R5, R6
        send_alt(1'b1, 2'b11, 15);                               // R3
        send_dual(15);                                           // R4
        send_alt(1'b0, 2'b10, 6);                                // R1 after nonzero outputs
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule